// File: doc/BRIEF.md
# BCD Seven-Segment Latch-Decoder with Phase Control

The block stores a four-bit binary-coded-decimal digit and turns it into the seven segment lines of a numeric readout. A strobe decides when a new digit is taken in. While the strobe is low, the last captured digit stays on the display even if the code input keeps changing. Codes above nine are not valid BCD, so they give a dark readout. A separate blanking input darkens the display whatever digit is stored.

A final polarity stage inverts every segment line when the phase input is high. Phase is tied low for common-cathode LEDs and high for common-anode LEDs. For a liquid-crystal panel, the phase input is driven with the same square wave as the backplane, so the segments get AC drive. Phase and blanking act on the output path without a register, so they take effect in the same cycle. The digit store is a register clocked by the system clock.

Top module: `bcd_seg_latch`

## Requirements
- R1: On a rising clock edge with `load_en` high, `digit_in` is captured. Its bits are weighted 8-4-2-1, with bit 3 the most significant. The segment outputs show the captured digit after that edge.
- R2: On a rising edge with `load_en` low, the stored digit does not change. The outputs keep showing the previously captured digit while `digit_in` changes.
- R3: With phase low and blanking low, `seg_out` bit 6 down to bit 0 carries segments a to g. The patterns are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R4: A stored digit from 10 to 15 drives all seven segments to 0 before the polarity stage.
- R5: With `blank_n_dark` high, all segments are 0 before the polarity stage, for any stored digit. The stored digit is not disturbed, and it shows again once blanking is released.
- R6: With `phase_in` high, every segment line is the bitwise inverse of the phase-low result. This includes blank readouts, which then drive all ones.
- R7: `phase_in` and `blank_n_dark` reach `seg_out` without a clock edge in between, and neither one alters the stored digit.
- R8: A synchronous active-high `rst` clears the stored digit to 0. The outputs then show the pattern for digit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the stored digit |
| digit_in | input | 4 | BCD code, 8-4-2-1 weighted |
| load_en | input | 1 | Strobe: capture `digit_in` on the edge when high, hold when low |
| blank_n_dark | input | 1 | Forces a dark readout when high |
| phase_in | input | 1 | Output polarity; high inverts every segment |
| seg_out | output | 7 | Segment lines, bit 6 = a through bit 0 = g |

## Verification
The clocked assertions assume that every input is a known 0 or 1 on each rising edge once reset is released. They also assume that reset is asserted at the first edge. The bench keeps to this by setting all inputs to defined values before the first clock and holding reset high for several cycles. The bench changes inputs only on the falling edge, so the sampled values never race the capture edge. Phase and blanking are also toggled between edges, with the strobe held low, so their combinational effect can be observed at the outputs.

// File: rtl/bcd_seg_latch.sv
module bcd_seg_latch #(
  parameter int CODE_W = 4,
  parameter int SEG_N  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] digit_in,
  input  logic              load_en,
  input  logic              blank_n_dark,
  input  logic              phase_in,
  output logic [SEG_N-1:0]  seg_out
);

  localparam logic [CODE_W-1:0] MAX_DIGIT = CODE_W'(9);

  logic [CODE_W-1:0] digit_q;
  logic [SEG_N-1:0]  pattern;
  logic [SEG_N-1:0]  lit;

  always_ff @(posedge clk) begin
    if (rst)          digit_q <= '0;
    else if (load_en) digit_q <= digit_in;
  end

  always_comb begin
    case (digit_q)
      CODE_W'(0): pattern = 7'b1111110;
      CODE_W'(1): pattern = 7'b0110000;
      CODE_W'(2): pattern = 7'b1101101;
      CODE_W'(3): pattern = 7'b1111001;
      CODE_W'(4): pattern = 7'b0110011;
      CODE_W'(5): pattern = 7'b1011011;
      CODE_W'(6): pattern = 7'b1011111;
      CODE_W'(7): pattern = 7'b1110000;
      CODE_W'(8): pattern = 7'b1111111;
      CODE_W'(9): pattern = 7'b1111011;
      default:    pattern = '0;
    endcase
  end

  assign lit     = blank_n_dark ? '0 : pattern;
  assign seg_out = lit ^ {SEG_N{phase_in}};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (digit_q == '0)); // R8

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (digit_q == $past(digit_in))); // R1

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(digit_q)); // R2

  AST_ILLEGAL_DARK: assert property (@(posedge clk) disable iff (rst)
    (digit_q > MAX_DIGIT) |-> (seg_out == {SEG_N{phase_in}})); // R4

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    blank_n_dark |-> (seg_out == {SEG_N{phase_in}})); // R5

  AST_PHASE_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (!blank_n_dark && digit_q == CODE_W'(8)) |-> (seg_out == {SEG_N{!phase_in}})); // R6

endmodule

// File: tb/test_bcd_seg_latch.sv
module test_bcd_seg_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit_in = 4'd0;
  logic       load_en = 1'b0;
  logic       blank_n_dark = 1'b0;
  logic       phase_in = 1'b0;
  logic [6:0] seg_out;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [6:0] EXP [16] = '{
    7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001,
    7'b0110011, 7'b1011011, 7'b1011111, 7'b1110000,
    7'b1111111, 7'b1111011, 7'b0000000, 7'b0000000,
    7'b0000000, 7'b0000000, 7'b0000000, 7'b0000000};

  always #4 clk = ~clk;

  bcd_seg_latch i_bcd_seg_latch (
    .clk(clk), .rst(rst), .digit_in(digit_in), .load_en(load_en),
    .blank_n_dark(blank_n_dark), .phase_in(phase_in), .seg_out(seg_out));

  task automatic check(input string req, input logic [6:0] exp);
    n_cmp++;
    if (seg_out !== exp) begin
      n_bad++;
      $display("FAIL %s: seg_out=%b expected=%b", req, seg_out, exp);
    end
  endtask

  task automatic load_digit(input logic [3:0] d);
    @(negedge clk);
    digit_in = d;
    load_en  = 1'b1;
    @(negedge clk);
    load_en  = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset digit 0", EXP[0]);

    for (int v = 0; v < 64; v++) begin
      load_digit(4'(v & 15));
      phase_in     = v[4];
      blank_n_dark = v[5];
      #1;
      if (v[5])      check("R5 blank", {7{v[4]}});
      else if (v[4]) check("R6 phase inverse", ~EXP[v & 15]);
      else if ((v & 15) > 9) check("R4 illegal dark", 7'b0);
      else           check("R3 R1 decode", EXP[v & 15]);
      @(negedge clk);
      phase_in = 1'b0;
      blank_n_dark = 1'b0;
    end

    load_digit(4'd5);
    check("R1 capture 5", EXP[5]);
    digit_in = 4'd2;
    repeat (3) @(negedge clk);
    check("R2 hold 5", EXP[5]);
    digit_in = 4'd12;
    @(negedge clk);
    check("R2 hold vs illegal", EXP[5]);

    phase_in = 1'b1;
    #1 check("R7 phase same cycle", ~EXP[5]);
    phase_in = 1'b0;
    blank_n_dark = 1'b1;
    #1 check("R7 blank same cycle", 7'b0);
    @(negedge clk);
    blank_n_dark = 1'b0;
    #1 check("R5 digit kept after blank", EXP[5]);

    load_digit(4'd9);
    check("R1 bit weights 9", EXP[9]);
    load_digit(4'd15);
    phase_in = 1'b1;
    #1 check("R6 illegal inverted", 7'b1111111);
    phase_in = 1'b0;

    load_digit(4'd7);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset clears", EXP[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule